// File: doc/BRIEF.md
# Front-End Control Register Bank

This block holds the configuration of a four-channel optical pick-up front end in sixteen 8-bit addressable slots. A controller writes and reads them over a plain synchronous register bus: a 4-bit address, 8-bit write data, a write strobe, a read strobe and 8-bit read data. The serial control link that feeds this bus lives outside the block. The stored fields drive the analog side directly: gain and offset codes for the four photodiode channels, the monitor output selector, the laser bias code, clock synthesis setup and a test word.

Two addresses write to a whole group in one access: one loads every channel gain and the other loads every channel offset. One slot is a read-only status word. It carries two sticky flags that record range events (over and under) of the high-frequency converter. A read of that word returns the flags and clears them, but an event in the same cycle as the clearing read is not lost.

Top module: `afe_cfg_bank`

## Requirements
- R1: While reset is low, and after it is released, every configuration output, the read data and both status flags are zero.
- R2: A write to address 0..3 (channel AC, BD, E, F in that order) sets only that channel's gain. A write to address 4..7 (same channel order) sets only that channel's offset to wdata[5:0]. On the ports, channel n occupies bits [6n+5:6n] of the packed gain or offset vector.
- R3: A gain write whose data exceeds 47 stores 47. Data of 47 or less is stored unchanged.
- R4: A write to address 14 stores the same gain value, clamped as in R3, into all four channels at once.
- R5: A write to address 15 stores wdata[5:0] into all four offsets at once.
- R6: Address 8 holds the monitor selector, coded 0=HF, 1=AC, 2=BD, 3=E, 4=F. A write with data above 4 leaves the selector unchanged.
- R7: Address 9 stores the laser bias code as wdata[5:0]. Address 10 stores the 8-bit clock setup word. Address 12 stores the 8-bit test word. Each reads back zero-extended.
- R8: Address 11 reads as {6'b0, under, over}. Bit 0 is set by an overflow event and bit 1 by an underflow event, and each stays set until a read of address 11 clears it.
- R9: An event that arrives in the same cycle as a clearing read of address 11 is not shown in that read. It stays set and appears in the next read.
- R10: Writes to address 11 and address 13 change nothing. Reads of address 13, 14 and 15 return zero.
- R11: Read data loads on the clock edge that samples the read strobe, so it is valid from the next cycle. It holds its value while the strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 8 | Registered read data |
| hf_ovf_evt | input | 1 | Converter overflow event pulse |
| hf_udf_evt | input | 1 | Converter underflow event pulse |
| gain_codes | output | 24 | Packed per-channel gain codes |
| ofs_codes | output | 24 | Packed per-channel offset codes |
| mon_sel | output | 3 | Monitor output selector |
| laser_code | output | 6 | Laser bias code |
| pll_cfg | output | 8 | Clock synthesis setup |
| test_cfg | output | 8 | Test mode word |

## Verification
The main function is exercised with a table of write/readback pairs. The gain data includes values below 47, exactly 47, just above and far above 47, so clamping can be told apart from truncation to six bits. Broadcast writes are followed by reads of a single channel, and single-channel writes made after a broadcast show that the other channels keep their values. The status word is tested with isolated events, with an event that coincides with a clearing read, and with both flags pending at once. These cases separate clear-on-read from event priority.

// File: rtl/afe_cfg_pkg.sv
package afe_cfg_pkg;
  localparam int ADDR_W = 4;
  localparam int DATA_W = 8;
  localparam int CODE_W = 6;
  localparam int NUM_CH = 4;
  localparam int MON_W  = 3;
  localparam int NFLAG  = 2;

  localparam logic [ADDR_W-1:0] A_GAIN0    = 4'h0;
  localparam logic [ADDR_W-1:0] A_OFS0     = 4'h4;
  localparam logic [ADDR_W-1:0] A_MON      = 4'h8;
  localparam logic [ADDR_W-1:0] A_LASER    = 4'h9;
  localparam logic [ADDR_W-1:0] A_PLL      = 4'hA;
  localparam logic [ADDR_W-1:0] A_STAT     = 4'hB;
  localparam logic [ADDR_W-1:0] A_TEST     = 4'hC;
  localparam logic [ADDR_W-1:0] A_SPARE    = 4'hD;
  localparam logic [ADDR_W-1:0] A_GAIN_ALL = 4'hE;
  localparam logic [ADDR_W-1:0] A_OFS_ALL  = 4'hF;

  localparam logic [DATA_W-1:0] GAIN_MAX = 8'd47;
  localparam logic [DATA_W-1:0] MON_MAX  = 8'd4;
endpackage

// File: rtl/afe_cfg_rstsync.sv
module afe_cfg_rstsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_a,
  output logic rst_n_s
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_a) begin
    if (!rst_n_a) sync_q <= '0;
    else          sync_q <= sync_d;
  end

  assign rst_n_s = sync_q[STAGES-1];
endmodule

// File: rtl/afe_cfg_wdec.sv
module afe_cfg_wdec
  import afe_cfg_pkg::*;
(
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  output logic [NUM_CH-1:0] gain_we,
  output logic [NUM_CH-1:0] ofs_we,
  output logic              mon_we,
  output logic              laser_we,
  output logic              pll_we,
  output logic              test_we
);
  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    assign gain_we[ch] = wr_en && ((addr == A_GAIN0 + ADDR_W'(ch)) || (addr == A_GAIN_ALL));
    assign ofs_we[ch]  = wr_en && ((addr == A_OFS0 + ADDR_W'(ch))  || (addr == A_OFS_ALL));
  end

  // Status and spare slots have no enable: writes there fall away.
  assign mon_we   = wr_en && (addr == A_MON);
  assign laser_we = wr_en && (addr == A_LASER);
  assign pll_we   = wr_en && (addr == A_PLL);
  assign test_we  = wr_en && (addr == A_TEST);
endmodule

// File: rtl/afe_cfg_sticky.sv
module afe_cfg_sticky #(
  parameter int NF = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NF-1:0] evt,
  input  logic          clr,
  output logic [NF-1:0] flags
);
  logic [NF-1:0] flag_q;
  logic [NF-1:0] flag_d;

  for (genvar i = 0; i < NF; i++) begin : g_flag
    // A new event wins over a clear in the same cycle.
    assign flag_d[i] = evt[i] | (flag_q[i] & ~clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= '0;
    else        flag_q <= flag_d;
  end

  assign flags = flag_q;
endmodule

// File: rtl/afe_cfg_rdmux.sv
module afe_cfg_rdmux
  import afe_cfg_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     rd_en,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [NUM_CH*CODE_W-1:0] gain_codes,
  input  logic [NUM_CH*CODE_W-1:0] ofs_codes,
  input  logic [MON_W-1:0]         mon_sel,
  input  logic [CODE_W-1:0]        laser_code,
  input  logic [DATA_W-1:0]        pll_cfg,
  input  logic [DATA_W-1:0]        test_cfg,
  input  logic [NFLAG-1:0]         status,
  output logic [DATA_W-1:0]        rdata
);
  logic [DATA_W-1:0] rd_val;
  logic [DATA_W-1:0] rdata_d;
  logic [DATA_W-1:0] rdata_q;

  always_comb begin
    rd_val = '0;
    for (int ch = 0; ch < NUM_CH; ch++) begin
      if (addr == A_GAIN0 + ADDR_W'(ch)) rd_val = DATA_W'(gain_codes[ch*CODE_W +: CODE_W]);
      if (addr == A_OFS0 + ADDR_W'(ch))  rd_val = DATA_W'(ofs_codes[ch*CODE_W +: CODE_W]);
    end
    case (addr)
      A_MON:   rd_val = DATA_W'(mon_sel);
      A_LASER: rd_val = DATA_W'(laser_code);
      A_PLL:   rd_val = pll_cfg;
      A_STAT:  rd_val = DATA_W'(status);
      A_TEST:  rd_val = test_cfg;
      default: ;
    endcase
  end

  always_comb begin
    rdata_d = rd_en ? rd_val : rdata_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata_q <= '0;
    else        rdata_q <= rdata_d;
  end

  assign rdata = rdata_q;
endmodule

// File: rtl/afe_cfg_bank.sv
module afe_cfg_bank
  import afe_cfg_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [ADDR_W-1:0]        bus_addr,
  input  logic [DATA_W-1:0]        bus_wdata,
  input  logic                     bus_wr,
  input  logic                     bus_rd,
  output logic [DATA_W-1:0]        bus_rdata,
  input  logic                     hf_ovf_evt,
  input  logic                     hf_udf_evt,
  output logic [NUM_CH*CODE_W-1:0] gain_codes,
  output logic [NUM_CH*CODE_W-1:0] ofs_codes,
  output logic [MON_W-1:0]         mon_sel,
  output logic [CODE_W-1:0]        laser_code,
  output logic [DATA_W-1:0]        pll_cfg,
  output logic [DATA_W-1:0]        test_cfg
);
  logic              rst_n_s;
  logic [NUM_CH-1:0] gain_we;
  logic [NUM_CH-1:0] ofs_we;
  logic              mon_we, laser_we, pll_we, test_we;
  logic [CODE_W-1:0] gain_wval;
  logic              mon_ok;
  logic              stat_clr;
  logic [NFLAG-1:0]  stat_flags;

  afe_cfg_rstsync #(.STAGES(2)) u_rst (
    .clk     (clk),
    .rst_n_a (rst_n),
    .rst_n_s (rst_n_s)
  );

  afe_cfg_wdec u_wdec (
    .wr_en    (bus_wr),
    .addr     (bus_addr),
    .gain_we  (gain_we),
    .ofs_we   (ofs_we),
    .mon_we   (mon_we),
    .laser_we (laser_we),
    .pll_we   (pll_we),
    .test_we  (test_we)
  );

  // Clamp at write time so the stored code is always legal.
  assign gain_wval = (bus_wdata > GAIN_MAX) ? GAIN_MAX[CODE_W-1:0] : bus_wdata[CODE_W-1:0];
  assign mon_ok    = (bus_wdata <= MON_MAX);

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    logic [CODE_W-1:0] gain_q, gain_d;
    logic [CODE_W-1:0] ofs_q, ofs_d;

    always_comb begin
      gain_d = gain_we[ch] ? gain_wval : gain_q;
      ofs_d  = ofs_we[ch] ? bus_wdata[CODE_W-1:0] : ofs_q;
    end

    always_ff @(posedge clk or negedge rst_n_s) begin
      if (!rst_n_s) begin
        gain_q <= '0;
        ofs_q  <= '0;
      end else begin
        gain_q <= gain_d;
        ofs_q  <= ofs_d;
      end
    end

    assign gain_codes[ch*CODE_W +: CODE_W] = gain_q;
    assign ofs_codes[ch*CODE_W +: CODE_W]  = ofs_q;
  end

  logic [MON_W-1:0]  mon_q, mon_d;
  logic [CODE_W-1:0] laser_q, laser_d;
  logic [DATA_W-1:0] pll_q, pll_d;
  logic [DATA_W-1:0] test_q, test_d;

  always_comb begin
    mon_d   = (mon_we && mon_ok) ? bus_wdata[MON_W-1:0] : mon_q;
    laser_d = laser_we ? bus_wdata[CODE_W-1:0] : laser_q;
    pll_d   = pll_we ? bus_wdata : pll_q;
    test_d  = test_we ? bus_wdata : test_q;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      mon_q   <= '0;
      laser_q <= '0;
      pll_q   <= '0;
      test_q  <= '0;
    end else begin
      mon_q   <= mon_d;
      laser_q <= laser_d;
      pll_q   <= pll_d;
      test_q  <= test_d;
    end
  end

  assign mon_sel    = mon_q;
  assign laser_code = laser_q;
  assign pll_cfg    = pll_q;
  assign test_cfg   = test_q;

  assign stat_clr = bus_rd && (bus_addr == A_STAT);

  afe_cfg_sticky #(.NF(NFLAG)) u_sticky (
    .clk   (clk),
    .rst_n (rst_n_s),
    .evt   ({hf_udf_evt, hf_ovf_evt}),
    .clr   (stat_clr),
    .flags (stat_flags)
  );

  afe_cfg_rdmux u_rdmux (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .rd_en      (bus_rd),
    .addr       (bus_addr),
    .gain_codes (gain_codes),
    .ofs_codes  (ofs_codes),
    .mon_sel    (mon_q),
    .laser_code (laser_q),
    .pll_cfg    (pll_q),
    .test_cfg   (test_q),
    .status     (stat_flags),
    .rdata      (bus_rdata)
  );
endmodule

// File: rtl/afe_cfg_bank_chk.sv
module afe_cfg_bank_chk
  import afe_cfg_pkg::*;
(
  input logic                     clk,
  input logic                     rst_n,
  input logic [ADDR_W-1:0]        bus_addr,
  input logic                     bus_wr,
  input logic                     bus_rd,
  input logic [DATA_W-1:0]        bus_rdata,
  input logic                     hf_ovf_evt,
  input logic [NUM_CH*CODE_W-1:0] gain_codes,
  input logic [NUM_CH*CODE_W-1:0] ofs_codes,
  input logic [MON_W-1:0]         mon_sel,
  input logic [CODE_W-1:0]        laser_code,
  input logic [DATA_W-1:0]        pll_cfg,
  input logic [DATA_W-1:0]        test_cfg
);
  logic stat_rd;
  assign stat_rd = bus_rd && (bus_addr == A_STAT);

  always @(negedge clk) begin
    if (!rst_n) begin
      a_reset_r1: assert (gain_codes == '0 && ofs_codes == '0 && mon_sel == '0 &&
                          laser_code == '0 && pll_cfg == '0 && test_cfg == '0 && bus_rdata == '0)
        else $error("R1 outputs not cleared in reset");
    end
  end

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_cap
    p_gain_cap_r3: assert property (@(posedge clk) disable iff (!rst_n)
      gain_codes[ch*CODE_W +: CODE_W] <= GAIN_MAX[CODE_W-1:0]);
  end

  p_bcast_gain_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_GAIN_ALL) |=>
      (gain_codes[0 +: CODE_W] == gain_codes[CODE_W +: CODE_W]) &&
      (gain_codes[0 +: CODE_W] == gain_codes[2*CODE_W +: CODE_W]) &&
      (gain_codes[0 +: CODE_W] == gain_codes[3*CODE_W +: CODE_W]));

  p_bcast_ofs_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_OFS_ALL) |=>
      (ofs_codes[0 +: CODE_W] == ofs_codes[CODE_W +: CODE_W]) &&
      (ofs_codes[0 +: CODE_W] == ofs_codes[2*CODE_W +: CODE_W]) &&
      (ofs_codes[0 +: CODE_W] == ofs_codes[3*CODE_W +: CODE_W]));

  p_mon_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    DATA_W'(mon_sel) <= MON_MAX);

  p_stat_pad_r8: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rd |=> (bus_rdata[DATA_W-1:NFLAG] == '0));

  p_evt_kept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && $past(stat_rd) && $past(hf_ovf_evt)) |=> bus_rdata[0]);

  p_void_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && (bus_addr == A_SPARE || bus_addr == A_GAIN_ALL || bus_addr == A_OFS_ALL))
      |=> (bus_rdata == '0));

  p_void_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && (bus_addr == A_STAT || bus_addr == A_SPARE)) |=>
      ($stable(gain_codes) && $stable(ofs_codes) && $stable(mon_sel) &&
       $stable(laser_code) && $stable(pll_cfg) && $stable(test_cfg)));

  p_rd_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata));
endmodule

bind afe_cfg_bank afe_cfg_bank_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n_s),
  .bus_addr   (bus_addr),
  .bus_wr     (bus_wr),
  .bus_rd     (bus_rd),
  .bus_rdata  (bus_rdata),
  .hf_ovf_evt (hf_ovf_evt),
  .gain_codes (gain_codes),
  .ofs_codes  (ofs_codes),
  .mon_sel    (mon_sel),
  .laser_code (laser_code),
  .pll_cfg    (pll_cfg),
  .test_cfg   (test_cfg)
);

// File: tb/afe_cfg_bank_tb_top.sv
`timescale 1ns/1ps
module afe_cfg_bank_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  bus_addr;
  logic [7:0]  bus_wdata;
  logic        bus_wr, bus_rd;
  logic [7:0]  bus_rdata;
  logic        hf_ovf_evt, hf_udf_evt;
  logic [23:0] gain_codes, ofs_codes;
  logic [2:0]  mon_sel;
  logic [5:0]  laser_code;
  logic [7:0]  pll_cfg, test_cfg;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  afe_cfg_bank dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .hf_ovf_evt(hf_ovf_evt), .hf_udf_evt(hf_udf_evt),
    .gain_codes(gain_codes), .ofs_codes(ofs_codes), .mon_sel(mon_sel),
    .laser_code(laser_code), .pll_cfg(pll_cfg), .test_cfg(test_cfg)
  );

  // {write addr, write data, read addr, expected read data}
  localparam int NVEC = 18;
  localparam logic [23:0] VEC [NVEC] = '{
    {4'h0, 8'h15, 4'h0, 8'h15},
    {4'h1, 8'h2F, 4'h1, 8'h2F},
    {4'h2, 8'h30, 4'h2, 8'h2F},
    {4'h3, 8'hFF, 4'h3, 8'h2F},
    {4'h4, 8'hC5, 4'h4, 8'h05},
    {4'h7, 8'h3F, 4'h7, 8'h3F},
    {4'hE, 8'h09, 4'h3, 8'h09},
    {4'hE, 8'h80, 4'h0, 8'h2F},
    {4'hF, 8'h6A, 4'h5, 8'h2A},
    {4'h9, 8'hFF, 4'h9, 8'h3F},
    {4'hA, 8'hA5, 4'hA, 8'hA5},
    {4'hC, 8'h5A, 4'hC, 8'h5A},
    {4'h8, 8'h03, 4'h8, 8'h03},
    {4'h8, 8'h07, 4'h8, 8'h03},
    {4'hB, 8'hFF, 4'hB, 8'h00},
    {4'hD, 8'h77, 4'hD, 8'h00},
    {4'h0, 8'h11, 4'hE, 8'h00},
    {4'h0, 8'h12, 4'hF, 8'h00}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic pulse(input bit ovf, input bit udf);
    hf_ovf_evt = ovf; hf_udf_evt = udf;
    @(negedge clk);
    hf_ovf_evt = 1'b0; hf_udf_evt = 1'b0;
  endtask

  task automatic all_zero(input string tag);
    chk(tag, {gain_codes, ofs_codes}, '0);
    chk(tag, {mon_sel, laser_code, pll_cfg, test_cfg, bus_rdata}, '0);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; bus_addr = '0; bus_wdata = '0; bus_wr = 1'b0; bus_rd = 1'b0;
    hf_ovf_evt = 1'b0; hf_udf_evt = 1'b0;
    repeat (4) @(negedge clk);
    all_zero("R1 in reset");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    all_zero("R1 after release");
    rd(4'hB); chk("R1 status after reset", bus_rdata, 8'h00);

    // Table walk: R2/R3/R4/R5/R6/R7/R10 write then read back
    for (int i = 0; i < NVEC; i++) begin
      wr(VEC[i][23:20], VEC[i][19:12]);
      rd(VEC[i][11:8]);
      chk($sformatf("table R2/R3/R4/R5/R6/R7/R10 entry %0d", i), bus_rdata, VEC[i][7:0]);
    end

    chk("R7 laser port", laser_code, 6'h3F);
    chk("R7 pll port", pll_cfg, 8'hA5);
    chk("R7 test port", test_cfg, 8'h5A);

    // R2: single-channel writes leave neighbours alone
    wr(4'hE, 8'd10); wr(4'h2, 8'd20);
    chk("R2 gain ports", gain_codes, {6'd10, 6'd20, 6'd10, 6'd10});
    wr(4'hF, 8'h07); wr(4'h6, 8'h21);
    chk("R2 offset ports", ofs_codes, {6'd7, 6'd33, 6'd7, 6'd7});
    wr(4'h0, 8'd47);
    chk("R3 boundary 47 kept", gain_codes[5:0], 6'd47);

    // R6: selector range
    wr(4'h8, 8'd4); chk("R6 select F", mon_sel, 3'd4);
    wr(4'h8, 8'd5); chk("R6 code 5 ignored", mon_sel, 3'd4);
    wr(4'h8, 8'd0); chk("R6 select HF", mon_sel, 3'd0);

    // R10: writes to status and spare leave every port as it was
    begin
      logic [75:0] snap;
      snap = {gain_codes, ofs_codes, mon_sel, laser_code, pll_cfg, test_cfg};
      wr(4'hB, 8'hFF); wr(4'hD, 8'hFF);
      chk("R10 void writes", {gain_codes, ofs_codes, mon_sel, laser_code, pll_cfg, test_cfg}, snap);
      rd(4'hB); chk("R10 status untouched by write", bus_rdata, 8'h00);
    end

    // R8: sticky flags, clear on read
    pulse(1'b1, 1'b0);
    rd(4'hB); chk("R8 overflow latched", bus_rdata, 8'h01);
    rd(4'hB); chk("R8 overflow cleared", bus_rdata, 8'h00);
    pulse(1'b0, 1'b1); repeat (2) @(negedge clk);
    rd(4'hB); chk("R8 underflow latched", bus_rdata, 8'h02);
    rd(4'hB); chk("R8 underflow cleared", bus_rdata, 8'h00);

    // R9: event in the clearing cycle survives
    hf_ovf_evt = 1'b1; bus_addr = 4'hB; bus_rd = 1'b1;
    @(negedge clk);
    hf_ovf_evt = 1'b0; bus_rd = 1'b0;
    chk("R9 read with concurrent event", bus_rdata, 8'h00);
    rd(4'hB); chk("R9 event kept", bus_rdata, 8'h01);
    pulse(1'b0, 1'b1);
    hf_ovf_evt = 1'b1; bus_addr = 4'hB; bus_rd = 1'b1;
    @(negedge clk);
    hf_ovf_evt = 1'b0; bus_rd = 1'b0;
    chk("R9 pending underflow shown", bus_rdata, 8'h02);
    rd(4'hB); chk("R9 overflow survived, underflow cleared", bus_rdata, 8'h01);
    rd(4'hB); chk("R9 both clear", bus_rdata, 8'h00);

    // R11: read data holds without strobe
    rd(4'hA); chk("R11 read loads", bus_rdata, 8'hA5);
    bus_addr = 4'h0;
    repeat (3) @(negedge clk);
    chk("R11 read data holds", bus_rdata, 8'hA5);

    // R1: reset in mid-run clears state and flags
    pulse(1'b1, 1'b1);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    all_zero("R1 mid-run reset");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    rd(4'hB); chk("R1 flags cleared by reset", bus_rdata, 8'h00);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule